// File: doc/BRIEF.md
# Prioritized Interrupt Request Encoder

This block gathers a set of level-sensitive interrupt request lines from peripherals. It samples them on every rising clock edge and reduces them to a single report for a processor core. The report is a level `irq` flag and a 6-bit interrupt number. Each external line is given a fixed number in the range 16 to 63. The lower half of the number space, 0 to 15, is left to sources inside the core. A smaller number means a more urgent request.

On the core side, an acceptance stage decides whether the reported request may be taken. It compares the reported number with a registered interrupt-enable bit and a registered priority limit, and raises a one-cycle `accept` strobe. The strobe fires once per reported request. It can fire again only after that request leaves the report, either because it went away or because a different request took its place. A peripheral holds its line until software services it. The per-line acknowledge input hides a line from the sample taken at that edge.

Top module: `irq_prio_encoder`

## Requirements
- R1: While `rst_n` is low, and after its release until a request is sampled, `irq_o` is 0, `irq_num_o` is 0 and `accept_o` is 0.
- R2: Request lines are sampled on the rising clock edge. `irq_o` is 1 in the cycle after an edge at which at least one unmasked line was high, and it stays 1 for as long as such a line stays high.
- R3: Line k (0 to 47) is reported as number k+16, so a reported number is never below 16.
- R4: When several lines are pending, the lowest-indexed line is reported, which is also the smallest number.
- R5: With no line pending, `irq_o` is 0, `irq_num_o` is 0 and `accept_o` is 0.
- R6: A line whose `ack_i` bit is high at an edge is left out of the sample taken at that edge. The next lower-priority pending line is reported instead.
- R7: `accept_o` is 1 only if `irq_o` is 1, the enable sampled at the last edge was 1, and `irq_num_o` is less than or equal to the limit sampled at the last edge. Equality is accepted.
- R8: `accept_o` is high for one cycle per reported request. While the same number stays reported, it does not rise again.
- R9: The strobe re-arms when `irq_o` falls or when a different number is reported. A higher-priority arrival, or the return to an earlier request after it, is accepted again.
- R10: If the limit or the enable changes so that the pending request becomes acceptable, `accept_o` rises one edge later, without the line being dropped and raised again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_i | input | 48 | Level request lines; bit k maps to number k+16 |
| ack_i | input | 48 | Per-line acknowledge; masks the line at that edge |
| ie_i | input | 1 | Interrupt enable for the acceptance stage |
| thr_i | input | 6 | Priority limit; numbers at or below it are accepted |
| irq_o | output | 1 | Level flag: a request is pending |
| irq_num_o | output | 6 | Number of the most urgent pending request, 0 when idle |
| accept_o | output | 1 | One-cycle strobe: the core takes the reported request |

## Verification
The assertions compare each output with the inputs as they stood at the previous edge. They therefore assume that `req_i` and `ack_i` hold 0 while reset is applied, so that the first comparison after release starts from an empty sample. The bench meets this by driving every input to 0 before the first edge and by changing inputs only at falling edges. Each value is then sampled once, at a well-defined rising edge. The acceptance checks also assume that the enable and the limit are single-edge samples. The bench never changes them more than once between two rising edges.

// File: rtl/irq_enc_pkg.sv
package irq_enc_pkg;
  localparam int unsigned NUM_W     = 6;
  localparam int unsigned FIRST_EXT = 16;

  typedef logic [NUM_W-1:0] irq_num_t;

  // External line index to interrupt number.
  function automatic irq_num_t map_line(input int unsigned line);
    return irq_num_t'(FIRST_EXT + line);
  endfunction

  // Acceptance rule: enabled and not less urgent than the limit.
  function automatic logic may_take(input logic en, input irq_num_t num,
                                    input irq_num_t limit);
    return en && (num <= limit);
  endfunction
endpackage

// File: rtl/irq_line_sampler.sv
module irq_line_sampler #(
  parameter int unsigned NUM_LINES = 48
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_LINES-1:0] req_i,
  input  logic [NUM_LINES-1:0] ack_i,
  output logic [NUM_LINES-1:0] pend_o
);
  for (genvar g = 0; g < NUM_LINES; g++) begin : g_line
    always_ff @(posedge clk) begin
      if (!rst_n) pend_o[g] <= 1'b0;
      else        pend_o[g] <= req_i[g] & ~ack_i[g];
    end
  end
endmodule

// File: rtl/irq_prio_pick.sv
module irq_prio_pick #(
  parameter int unsigned NUM_LINES = 48,
  parameter int unsigned IDX_W     = $clog2(NUM_LINES)
) (
  input  logic [NUM_LINES-1:0] pend_i,
  output logic                 any_o,
  output logic [IDX_W-1:0]     idx_o
);
  // Scan from the top down so the lowest index is the last one written.
  always_comb begin
    any_o = 1'b0;
    idx_o = '0;
    for (int i = NUM_LINES - 1; i >= 0; i--) begin
      if (pend_i[i]) begin
        any_o = 1'b1;
        idx_o = IDX_W'(i);
      end
    end
  end
endmodule

// File: rtl/irq_take_ctl.sv
module irq_take_ctl
  import irq_enc_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     ie_i,
  input  irq_num_t thr_i,
  input  logic     irq_i,
  input  irq_num_t num_i,
  output logic     accept_o,
  output logic     eligible_o,
  output logic     rearm_o
);
  logic     ie_q;
  irq_num_t thr_q;
  logic     taken_v;
  irq_num_t taken_num;
  logic     same_as_taken;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ie_q  <= 1'b0;
      thr_q <= '0;
    end else begin
      ie_q  <= ie_i;
      thr_q <= thr_i;
    end
  end

  assign eligible_o    = irq_i && may_take(ie_q, num_i, thr_q);
  assign same_as_taken = taken_v && (taken_num == num_i);
  assign accept_o      = eligible_o && !same_as_taken;
  assign rearm_o       = taken_v && (!irq_i || (taken_num != num_i));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      taken_v   <= 1'b0;
      taken_num <= '0;
    end else if (accept_o) begin
      taken_v   <= 1'b1;
      taken_num <= num_i;
    end else if (rearm_o) begin
      taken_v   <= 1'b0;
    end
  end
endmodule

// File: rtl/irq_prio_encoder.sv
module irq_prio_encoder
  import irq_enc_pkg::*;
#(
  parameter int unsigned NUM_LINES = 48
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_LINES-1:0] req_i,
  input  logic [NUM_LINES-1:0] ack_i,
  input  logic                 ie_i,
  input  logic [NUM_W-1:0]     thr_i,
  output logic                 irq_o,
  output logic [NUM_W-1:0]     irq_num_o,
  output logic                 accept_o
);
  localparam int unsigned IDX_W = $clog2(NUM_LINES);

  logic [NUM_LINES-1:0] pend_w;
  logic                 any_w;
  logic [IDX_W-1:0]     idx_w;
  irq_num_t             num_w;
  logic                 eligible_w;
  logic                 rearm_w;

  irq_line_sampler #(.NUM_LINES(NUM_LINES)) u_samp (
    .clk(clk), .rst_n(rst_n), .req_i(req_i), .ack_i(ack_i), .pend_o(pend_w)
  );

  irq_prio_pick #(.NUM_LINES(NUM_LINES), .IDX_W(IDX_W)) u_pick (
    .pend_i(pend_w), .any_o(any_w), .idx_o(idx_w)
  );

  assign num_w     = any_w ? map_line(int'(idx_w)) : '0;
  assign irq_o     = any_w;
  assign irq_num_o = num_w;

  irq_take_ctl u_take (
    .clk(clk), .rst_n(rst_n), .ie_i(ie_i), .thr_i(thr_i),
    .irq_i(any_w), .num_i(num_w),
    .accept_o(accept_o), .eligible_o(eligible_w), .rearm_o(rearm_w)
  );
endmodule

// File: rtl/irq_enc_chk.sv
module irq_enc_chk
  import irq_enc_pkg::*;
#(
  parameter int unsigned NUM_LINES = 48
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic [NUM_LINES-1:0] req_i,
  input logic [NUM_LINES-1:0] ack_i,
  input logic                 ie_i,
  input logic [NUM_W-1:0]     thr_i,
  input logic                 irq_o,
  input logic [NUM_W-1:0]     irq_num_o,
  input logic                 accept_o,
  input logic                 eligible_w,
  input logic                 rearm_w
);
  AST_IRQ_TRACKS_SAMPLE: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> (irq_o == |($past(req_i) & ~$past(ack_i)))); // R2
  AST_NUM_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> (irq_num_o >= NUM_W'(FIRST_EXT))); // R3
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_o |-> (irq_num_o == '0 && !accept_o)); // R5
  AST_ACCEPT_GATE: assert property (@(posedge clk) disable iff (!rst_n)
    (accept_o && $past(rst_n)) |-> (irq_o && $past(ie_i) && irq_num_o <= $past(thr_i))); // R7
  AST_ONE_SHOT: assert property (@(posedge clk) disable iff (!rst_n)
    accept_o |=> (!accept_o || irq_num_o != $past(irq_num_o))); // R8
  AST_ACCEPT_ELIGIBLE: assert property (@(posedge clk) disable iff (!rst_n)
    accept_o |-> eligible_w); // R7
  AST_REARM_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    (rearm_w && irq_o) |-> !$stable(irq_num_o)); // R9
endmodule

bind irq_prio_encoder irq_enc_chk #(.NUM_LINES(NUM_LINES)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_i(req_i), .ack_i(ack_i), .ie_i(ie_i),
  .thr_i(thr_i), .irq_o(irq_o), .irq_num_o(irq_num_o), .accept_o(accept_o),
  .eligible_w(eligible_w), .rearm_w(rearm_w)
);

// File: tb/sim_irq_prio_encoder.sv
module sim_irq_prio_encoder;
  localparam int CLK_PERIOD = 10;
  localparam int NL = 48;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [NL-1:0] req = '0;
  logic [NL-1:0] ack = '0;
  logic          ie = 1'b0;
  logic [5:0]    thr = '0;
  logic          irq;
  logic [5:0]    num;
  logic          acc;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  irq_prio_encoder u0 (
    .clk(clk), .rst_n(rst_n), .req_i(req), .ack_i(ack), .ie_i(ie),
    .thr_i(thr), .irq_o(irq), .irq_num_o(num), .accept_o(acc)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [5:0] expect_num(input int line);
    return 6'(line + 16);
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic t_reset();
    step();
    chk(irq == 1'b0, "R1 irq in reset", irq, 0);
    chk(num == 6'd0, "R1 num in reset", num, 0);
    chk(acc == 1'b0, "R1 accept in reset", acc, 0);
    rst_n = 1'b1;
    step();
    chk(irq == 1'b0 && num == 0 && acc == 0, "R1 after release", {irq, num, acc}, 0);
  endtask

  task automatic t_single();
    int lines[4] = '{0, 1, 23, 47};
    ie = 1'b0;
    foreach (lines[i]) begin
      req = '0;
      req[lines[i]] = 1'b1;
      step();
      chk(irq == 1'b1, "R2 irq for single line", irq, 1);
      chk(num == expect_num(lines[i]), "R3 number of single line", num, expect_num(lines[i]));
      chk(acc == 1'b0, "R7 no accept with enable low", acc, 0);
      step();
      chk(irq == 1'b1, "R2 irq held while pending", irq, 1);
    end
    req = '0;
    step();
    chk(irq == 1'b0 && num == 6'd0, "R5 idle after clear", {irq, num}, 0);
  endtask

  task automatic t_multi();
    req = '0;
    req[40] = 1'b1; req[9] = 1'b1; req[5] = 1'b1;
    step();
    chk(num == expect_num(5), "R4 lowest index wins", num, expect_num(5));
    req[5] = 1'b0;
    step();
    chk(num == expect_num(9), "R4 next after removal", num, expect_num(9));
    req = '0;
    step();
  endtask

  task automatic t_ack();
    req = '0;
    req[3] = 1'b1; req[7] = 1'b1;
    ack[3] = 1'b1;
    step();
    chk(num == expect_num(7), "R6 acked line masked", num, expect_num(7));
    ack = '0;
    step();
    chk(num == expect_num(3), "R6 line back after ack drops", num, expect_num(3));
    req[7] = 1'b0;
    ack[3] = 1'b1;
    step();
    chk(irq == 1'b0, "R6 only line acked gives idle", irq, 0);
    chk(acc == 1'b0, "R5 no accept when idle", acc, 0);
    ack = '0;
    req = '0;
    step();
  endtask

  task automatic t_gate();
    req = '0;
    ie = 1'b1;
    thr = 6'd20;
    req[10] = 1'b1;
    step();
    chk(acc == 1'b0, "R7 above limit not accepted", acc, 0);
    step();
    chk(acc == 1'b0, "R7 above limit stays quiet", acc, 0);
    thr = 6'd26;
    step();
    chk(acc == 1'b1, "R10 limit raise accepts at equality", acc, 1);
    step();
    chk(acc == 1'b0, "R8 strobe one cycle", acc, 0);
    req = '0;
    step();
    ie = 1'b0;
    thr = 6'd63;
    req[12] = 1'b1;
    step();
    chk(acc == 1'b0, "R7 enable low blocks", acc, 0);
    ie = 1'b1;
    step();
    chk(acc == 1'b1, "R10 enable rise accepts", acc, 1);
    req = '0;
    step();
  endtask

  task automatic t_one_shot();
    ie = 1'b1;
    thr = 6'd63;
    req = '0;
    req[30] = 1'b1;
    step();
    chk(acc == 1'b1, "R8 first accept", acc, 1);
    for (int i = 0; i < 4; i++) begin
      step();
      chk(acc == 1'b0, "R8 no repeat while held", acc, 0);
    end
  endtask

  task automatic t_rearm();
    req[2] = 1'b1;
    step();
    chk(acc == 1'b1 && num == expect_num(2), "R9 higher priority accepted", acc, 1);
    step();
    chk(acc == 1'b0, "R8 higher one only once", acc, 0);
    req[2] = 1'b0;
    step();
    chk(acc == 1'b1 && num == expect_num(30), "R9 return to earlier accepted", acc, 1);
    req[30] = 1'b0;
    step();
    chk(irq == 1'b0 && acc == 1'b0, "R9 drop gives idle", acc, 0);
    req[30] = 1'b1;
    step();
    chk(acc == 1'b1, "R9 reassert accepted", acc, 1);
    req = '0;
    step();
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 5000);
    checks++;
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    finish_run();
  end

  initial begin
    t_reset();
    t_single();
    t_multi();
    t_ack();
    t_gate();
    t_one_shot();
    t_rearm();
    finish_run();
  end
endmodule